// File: doc/BRIEF.md
# Minimum Deadband Edge-Blocking Logic

This block post-processes two PWM channels, A and B, so that a channel's output edges keep a programmable minimum distance from the edges of a chosen reference. Each channel picks a reference. The reference can be its own PWM input, the input of the other channel, or one of several external lines that a selector picks from. The reference may first be inverted. Its falling edge is then stretched by a programmed number of clock cycles. The stretched signal is the blocking mask. The mask is merged with the channel's PWM input in one of two ways. An OR merge holds the output high during the mask, which delays the output's falling edge. An AND merge with the inverted mask holds the output low during the mask, which delays the output's rising edge.

Typical uses follow from these choices. An OR merge on a channel's own input lengthens its high time. An AND merge on its own inverted input postpones its rising edge. An AND merge on the other channel's input enforces a dead time between complementary outputs. An AND merge on an external line makes the output wait until a set time after a signal from elsewhere has fallen. With a 200 MHz module clock, a delay count of 4000 gives 20 µs. The reference and mask signals stay inside the block. Both outputs are registered.

Top module: `mdb_edge_block`

## Requirements
- R1: While `rst` is high, and on the clock after reset, both outputs are 0.
- R2: With a channel's enable at 0, its output equals its PWM input delayed by exactly one clock, whatever the other configuration fields hold.
- R3: OR merge (`and_mode`=0): whenever the enabled channel's input is 1, its output is 1 on the next clock. With the own input as reference (`ref_sel`=0), no inversion and delay D, the output falls D+1 clocks after the input falls, which is D clocks later than in bypass.
- R4: AND merge (`and_mode`=1): the mask is inverted and ANDed with the input, so whenever the enabled channel's input is 0, its output is 0 on the next clock. With the own input as reference and `invert`=1, the output rises D+1 clocks after the input rises.
- R5: A delay of 0 applies no stretch. The mask equals the (possibly inverted) reference, so the OR merge on the own input and the AND merge on the own inverted input both follow the input with one clock of latency.
- R6: `ref_sel`=1 takes the other channel's input as reference. With complementary inputs, the AND merge and no inversion, each output rises D+1 clocks after the other channel's input falls.
- R7: `ref_sel`=2 takes `ext_in[ext_sel]` as reference. With the AND merge, the output stays 0 until D+1 clocks after that line falls. The other external lines have no effect.
- R8: `ref_sel`=3 acts the same as `ref_sel`=0 (own input).
- R9: Every falling edge of the reference reloads the delay. A new falling edge during a stretch restarts the window, so the OR-merged output falls D+1 clocks after the last falling edge.
- R10: The two channels have separate configurations. A setting on one channel does not change the timing of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 1 | PWM input of channel A |
| b_in | input | 1 | PWM input of channel B |
| ext_in | input | N_EXT | External reference lines |
| a_en | input | 1 | Channel A blocking enable (0 = bypass) |
| a_ref_sel | input | 2 | Channel A reference: 0 own, 1 other channel, 2 external, 3 own |
| a_ext_sel | input | EXT_W | Channel A index into ext_in |
| a_invert | input | 1 | Invert channel A reference before stretching |
| a_and_mode | input | 1 | Channel A merge: 0 OR, 1 AND with inverted mask |
| a_delay | input | DLY_W | Channel A falling-edge stretch in clocks |
| b_en | input | 1 | Channel B blocking enable (0 = bypass) |
| b_ref_sel | input | 2 | Channel B reference: 0 own, 1 other channel, 2 external, 3 own |
| b_ext_sel | input | EXT_W | Channel B index into ext_in |
| b_invert | input | 1 | Invert channel B reference before stretching |
| b_and_mode | input | 1 | Channel B merge: 0 OR, 1 AND with inverted mask |
| b_delay | input | DLY_W | Channel B falling-edge stretch in clocks |
| a_out | output | 1 | Registered output of channel A |
| b_out | output | 1 | Registered output of channel B |

## Verification
Some properties hold on every cycle, and the assertions check these. Both outputs are clear after reset. A disabled channel repeats its input one clock later. An OR-merged output never drops while its input is high. An AND-merged output never rises while its input is low. The exact stretch length depends on the programmed delay and on which reference was chosen, so only the bench scenarios can show it. The same holds for reloading on a repeated falling edge, for dead time between complementary channels, for gating by an external line, and for the zero-delay and alias-select cases.

// File: rtl/mdb_pkg.sv
package mdb_pkg;

    typedef enum logic [1:0] {
        SRC_OWN     = 2'd0,
        SRC_PEER    = 2'd1,
        SRC_EXT     = 2'd2,
        SRC_OWN_ALT = 2'd3
    } ref_src_e;

    typedef struct packed {
        logic     en;
        ref_src_e src;
        logic     inv;
        logic     and_mode;
    } chan_mode_t;

    // Merge the PWM input with the blocking mask.
    function automatic logic merge_mask(logic and_mode, logic pwm, logic blk);
        return and_mode ? (pwm & ~blk) : (pwm | blk);
    endfunction

    function automatic int sel_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mdb_ref_mux.sv
module mdb_ref_mux
    import mdb_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int EXT_W = sel_width(N_EXT)
) (
    input  logic             own_i,
    input  logic             peer_i,
    input  logic [N_EXT-1:0] ext_i,
    input  ref_src_e         src_i,
    input  logic [EXT_W-1:0] ext_sel_i,
    input  logic             inv_i,
    output logic             ref_o
);

    logic ext_pick;
    logic raw_ref;

    always_comb begin
        ext_pick = 1'b0;
        for (int k = 0; k < N_EXT; k++) begin
            if (ext_sel_i == EXT_W'(k)) begin
                ext_pick = ext_i[k];
            end
        end
    end

    always_comb begin
        unique case (src_i)
            SRC_PEER: raw_ref = peer_i;
            SRC_EXT:  raw_ref = ext_pick;
            default:  raw_ref = own_i;
        endcase
    end

    assign ref_o = raw_ref ^ inv_i;

endmodule

// File: rtl/mdb_stretch.sv
module mdb_stretch #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             blk_o
);

    logic             ref_q;
    logic [DLY_W-1:0] cnt_q;
    logic             fall;
    logic             dly_nz;
    logic             cnt_nz;

    assign fall   = ref_q & ~ref_i;
    assign dly_nz = (delay_i != '0);
    assign cnt_nz = (cnt_q != '0);

    // High on the reference, on the falling-edge cycle, and while counting.
    assign blk_o = ref_i | cnt_nz | (fall & dly_nz);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            ref_q <= ref_i;
            if (fall) begin
                cnt_q <= dly_nz ? (delay_i - DLY_W'(1)) : '0;
            end else if (cnt_nz) begin
                cnt_q <= cnt_q - DLY_W'(1);
            end
        end
    end

endmodule

// File: rtl/mdb_out_stage.sv
module mdb_out_stage
    import mdb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_mode_t mode_i,
    input  logic       pwm_i,
    input  logic       blk_i,
    output logic       out_o
);

    logic nxt;

    always_comb begin
        if (mode_i.en) begin
            nxt = merge_mask(mode_i.and_mode, pwm_i, blk_i);
        end else begin
            nxt = pwm_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= 1'b0;
        end else begin
            out_o <= nxt;
        end
    end

endmodule

// File: rtl/mdb_edge_block.sv
module mdb_edge_block
    import mdb_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int DLY_W = 16,
    localparam int EXT_W = sel_width(N_EXT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_in,
    input  logic             b_in,
    input  logic [N_EXT-1:0] ext_in,
    input  logic             a_en,
    input  logic [1:0]       a_ref_sel,
    input  logic [EXT_W-1:0] a_ext_sel,
    input  logic             a_invert,
    input  logic             a_and_mode,
    input  logic [DLY_W-1:0] a_delay,
    input  logic             b_en,
    input  logic [1:0]       b_ref_sel,
    input  logic [EXT_W-1:0] b_ext_sel,
    input  logic             b_invert,
    input  logic             b_and_mode,
    input  logic [DLY_W-1:0] b_delay,
    output logic             a_out,
    output logic             b_out
);

    localparam int N_CH = 2;

    logic [N_CH-1:0] pwm;
    logic [N_CH-1:0] ref_w;
    logic [N_CH-1:0] blk_w;
    logic [N_CH-1:0] out_w;
    chan_mode_t       mode  [N_CH];
    logic [DLY_W-1:0] dly   [N_CH];
    logic [EXT_W-1:0] esel  [N_CH];

    assign pwm = {b_in, a_in};

    assign mode[0] = '{en: a_en, src: ref_src_e'(a_ref_sel),
                       inv: a_invert, and_mode: a_and_mode};
    assign mode[1] = '{en: b_en, src: ref_src_e'(b_ref_sel),
                       inv: b_invert, and_mode: b_and_mode};
    assign dly[0]  = a_delay;
    assign dly[1]  = b_delay;
    assign esel[0] = a_ext_sel;
    assign esel[1] = b_ext_sel;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        mdb_ref_mux #(
            .N_EXT (N_EXT),
            .EXT_W (EXT_W)
        ) u_mux (
            .own_i     (pwm[c]),
            .peer_i    (pwm[N_CH-1-c]),
            .ext_i     (ext_in),
            .src_i     (mode[c].src),
            .ext_sel_i (esel[c]),
            .inv_i     (mode[c].inv),
            .ref_o     (ref_w[c])
        );

        mdb_stretch #(
            .DLY_W (DLY_W)
        ) u_str (
            .clk     (clk),
            .rst     (rst),
            .ref_i   (ref_w[c]),
            .delay_i (dly[c]),
            .blk_o   (blk_w[c])
        );

        mdb_out_stage u_out (
            .clk    (clk),
            .rst    (rst),
            .mode_i (mode[c]),
            .pwm_i  (pwm[c]),
            .blk_i  (blk_w[c]),
            .out_o  (out_w[c])
        );
    end

    assign a_out = out_w[0];
    assign b_out = out_w[1];

endmodule

// File: rtl/mdb_edge_block_chk.sv
module mdb_edge_block_chk
    import mdb_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int DLY_W = 16,
    localparam int EXT_W = sel_width(N_EXT)
) (
    input logic             clk,
    input logic             rst,
    input logic             a_in,
    input logic             b_in,
    input logic [N_EXT-1:0] ext_in,
    input logic             a_en,
    input logic [1:0]       a_ref_sel,
    input logic [EXT_W-1:0] a_ext_sel,
    input logic             a_invert,
    input logic             a_and_mode,
    input logic [DLY_W-1:0] a_delay,
    input logic             b_en,
    input logic [1:0]       b_ref_sel,
    input logic [EXT_W-1:0] b_ext_sel,
    input logic             b_invert,
    input logic             b_and_mode,
    input logic [DLY_W-1:0] b_delay,
    input logic             a_out,
    input logic             b_out
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!a_out && !b_out));

    // R2
    a_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        !a_en |=> (a_out == $past(a_in)));

    // R2
    b_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> (b_out == $past(b_in)));

    // R3
    a_or_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (a_en && !a_and_mode && a_in) |=> a_out);

    // R3
    b_or_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (b_en && !b_and_mode && b_in) |=> b_out);

    // R4
    a_and_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_and_mode && !a_in) |=> !a_out);

    // R4
    b_and_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (b_en && b_and_mode && !b_in) |=> !b_out);

endmodule

bind mdb_edge_block mdb_edge_block_chk #(
    .N_EXT (N_EXT),
    .DLY_W (DLY_W)
) u_chk (.*);

// File: tb/test_mdb_edge_block.sv
module test_mdb_edge_block;

    localparam int N_EXT = 4;
    localparam int DLY_W = 16;
    localparam int EXT_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             a_in = 1'b0;
    logic             b_in = 1'b0;
    logic [N_EXT-1:0] ext_in = '0;
    logic             a_en = 1'b0;
    logic [1:0]       a_ref_sel = 2'd0;
    logic [EXT_W-1:0] a_ext_sel = '0;
    logic             a_invert = 1'b0;
    logic             a_and_mode = 1'b0;
    logic [DLY_W-1:0] a_delay = '0;
    logic             b_en = 1'b0;
    logic [1:0]       b_ref_sel = 2'd0;
    logic [EXT_W-1:0] b_ext_sel = '0;
    logic             b_invert = 1'b0;
    logic             b_and_mode = 1'b0;
    logic [DLY_W-1:0] b_delay = '0;
    logic             a_out;
    logic             b_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mdb_edge_block #(.N_EXT(N_EXT), .DLY_W(DLY_W)) i_mdb_edge_block (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .ext_in(ext_in),
        .a_en(a_en), .a_ref_sel(a_ref_sel), .a_ext_sel(a_ext_sel),
        .a_invert(a_invert), .a_and_mode(a_and_mode), .a_delay(a_delay),
        .b_en(b_en), .b_ref_sel(b_ref_sel), .b_ext_sel(b_ext_sel),
        .b_invert(b_invert), .b_and_mode(b_and_mode), .b_delay(b_delay),
        .a_out(a_out), .b_out(b_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count clocks until the chosen output reaches the level.
    task automatic wait_level(input int ch, input logic lvl, output int n);
        n = 0;
        for (int k = 1; k <= 200; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (((ch == 0) ? a_out : b_out) == lvl) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic cfg_a(input logic en, input logic [1:0] sel,
                         input logic [EXT_W-1:0] es, input logic inv,
                         input logic am, input int d);
        a_en = en; a_ref_sel = sel; a_ext_sel = es;
        a_invert = inv; a_and_mode = am; a_delay = DLY_W'(d);
    endtask

    task automatic cfg_b(input logic en, input logic [1:0] sel,
                         input logic [EXT_W-1:0] es, input logic inv,
                         input logic am, input int d);
        b_en = en; b_ref_sel = sel; b_ext_sel = es;
        b_invert = inv; b_and_mode = am; b_delay = DLY_W'(d);
    endtask

    task automatic t_reset();
        idle(3);
        check("R1 a_out in reset", int'(a_out), 0);
        check("R1 b_out in reset", int'(b_out), 0);
        a_in = 1'b1; b_in = 1'b1;
        idle(2);
        check("R1 a_out held in reset", int'(a_out), 0);
        a_in = 1'b0; b_in = 1'b0;
        rst = 1'b0;
        idle(2);
        check("R1 a_out after reset", int'(a_out), 0);
    endtask

    task automatic t_bypass();
        logic [11:0] pat_a = 12'b1011_0011_1010;
        logic [11:0] pat_b = 12'b0110_1100_0101;
        cfg_a(1'b0, 2'd2, 2'd1, 1'b1, 1'b1, 9);
        cfg_b(1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 4);
        idle(12);
        for (int k = 0; k < 12; k++) begin
            a_in = pat_a[k]; b_in = pat_b[k];
            @(posedge clk);
            @(negedge clk);
            check("R2 a bypass", int'(a_out), int'(pat_a[k]));
            check("R2 b bypass", int'(b_out), int'(pat_b[k]));
        end
        a_in = 1'b0; b_in = 1'b0;
        idle(12);
    endtask

    task automatic t_or_self();
        int n;
        cfg_a(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 5);
        a_in = 1'b1;
        wait_level(0, 1'b1, n);
        check("R3 OR rise latency", n, 1);
        idle(4);
        a_in = 1'b0;
        wait_level(0, 1'b0, n);
        check("R3 OR fall stretched", n, 6);
        idle(8);
    endtask

    task automatic t_and_self();
        int n;
        cfg_a(1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 8);
        a_in = 1'b0;
        idle(12);
        check("R4 AND low while input low", int'(a_out), 0);
        a_in = 1'b1;
        wait_level(0, 1'b1, n);
        check("R4 AND rise delayed", n, 9);
        a_in = 1'b0;
        wait_level(0, 1'b0, n);
        check("R4 AND fall latency", n, 1);
        idle(12);
    endtask

    task automatic t_zero_delay();
        int n;
        cfg_a(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 0);
        a_in = 1'b1;
        idle(4);
        a_in = 1'b0;
        wait_level(0, 1'b0, n);
        check("R5 OR zero delay fall", n, 1);
        cfg_a(1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 0);
        idle(4);
        a_in = 1'b1;
        wait_level(0, 1'b1, n);
        check("R5 AND zero delay rise", n, 1);
        a_in = 1'b0;
        idle(4);
    endtask

    task automatic t_peer();
        int n;
        cfg_a(1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 7);
        cfg_b(1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 4);
        a_in = 1'b1; b_in = 1'b0;
        idle(12);
        a_in = 1'b0; b_in = 1'b1;
        wait_level(1, 1'b1, n);
        check("R6 B rises after A falls", n, 5);
        idle(10);
        a_in = 1'b1; b_in = 1'b0;
        wait_level(0, 1'b1, n);
        check("R6 A rises after B falls", n, 8);
        a_in = 1'b0;
        idle(10);
    endtask

    task automatic t_ext();
        int n;
        cfg_a(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 0);
        cfg_b(1'b1, 2'd2, 2'd2, 1'b0, 1'b1, 6);
        ext_in = 4'b0100;
        b_in = 1'b1;
        idle(4);
        ext_in = 4'b0101;
        idle(2);
        ext_in = 4'b0100;
        idle(2);
        check("R7 unselected ext lines ignored", int'(b_out), 0);
        ext_in = 4'b0000;
        wait_level(1, 1'b1, n);
        check("R7 B waits on external fall", n, 7);
        b_in = 1'b0;
        idle(10);
    endtask

    task automatic t_alias();
        int n;
        cfg_b(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 0);
        cfg_a(1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 3);
        a_in = 1'b1;
        idle(4);
        a_in = 1'b0;
        wait_level(0, 1'b0, n);
        check("R8 select 3 uses own input", n, 4);
        idle(6);
    endtask

    task automatic t_retrigger();
        int n;
        int low_seen = 0;
        cfg_a(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 6);
        a_in = 1'b1;
        idle(4);
        a_in = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            if (a_out == 1'b0) low_seen++;
        end
        a_in = 1'b1;
        @(posedge clk); @(negedge clk);
        if (a_out == 1'b0) low_seen++;
        a_in = 1'b0;
        wait_level(0, 1'b0, n);
        check("R9 stays high across retrigger", low_seen, 0);
        check("R9 reload on second fall", n, 7);
        idle(10);
    endtask

    task automatic t_independent();
        int na = 0;
        int nb = 0;
        cfg_a(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 5);
        cfg_b(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 12);
        a_in = 1'b1; b_in = 1'b1;
        idle(4);
        a_in = 1'b0; b_in = 1'b0;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk); @(negedge clk);
            if (na == 0 && a_out == 1'b0) na = k;
            if (nb == 0 && b_out == 1'b0) nb = k;
        end
        check("R10 A fall with own delay", na, 6);
        check("R10 B unaffected by A", nb, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_bypass();
        t_or_self();
        t_and_self();
        t_zero_delay();
        t_peer();
        t_ext();
        t_alias();
        t_retrigger();
        t_independent();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule